// File: doc/BRIEF.md
# Outbound Buffer Release Unit

This block sits beside an outbound data mover and decides, for each local source pointer it is handed, whether the memory buffer behind that pointer is to be given back to a hardware free pool. The decision uses three transfer-wide controls: the transfer kind, a free-local flag and an override that ignores per-pointer inversion. It also uses each pointer's own invert bit. Pointers arrive as a valid/ready stream. Each carries an invert bit, a 4-bit backup count, a 3-bit pool number and a 36-bit byte address of any alignment.

When a buffer is released, the block rebuilds the start of the buffer by stepping back a number of 128-byte blocks from the pointer. It then presents a release request that carries this start address and the pool number. A single registered output stage holds the request until the pool side accepts it. While the request is held, the pointer stream is stalled, so requests leave in pointer order. A backup count larger than the pointer's block index cannot form a valid address. In that case the block drops the request and raises a one-cycle error pulse instead.

Top module: `buf_release_unit`

## Requirements
- R1: When the transfer kind is not outbound (kind encoding: 0 outbound, 1 inbound, 2 internal-only, 3 external-only), an accepted pointer produces neither a release request nor an error pulse.
- R2: For outbound with the ignore-invert control at 1, a pointer is released exactly when the free-local control is 1, whatever its invert bit is.
- R3: For outbound with the ignore-invert control at 0, a pointer is released exactly when free-local XOR the pointer's invert bit is 1.
- R4: A release request's address equals ((ptr_addr >> 7) - ptr_back) << 7, so its low 7 bits are zero for any pointer alignment; a result of block 0 is legal.
- R5: A release request carries the pool number of the pointer that caused it.
- R6: A release whose backup count exceeds the pointer's block index (ptr_addr >> 7) emits no request and pulses err_underflow for exactly one cycle, one clock after the pointer is accepted.
- R7: The backup and pool fields of a pointer that is not released have no effect: no request and no error appear, even when the backup would underflow.
- R8: A request appears one clock after its pointer is accepted. It holds valid, address and pool stable while rel_ready is 0, ptr_ready is 0 during that stall, and requests leave in pointer order.
- R9: After reset rel_valid and err_underflow are 0 and ptr_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_kind | input | 2 | Transfer kind (0 outbound, 1 inbound, 2 internal-only, 3 external-only) |
| hdr_ign_inv | input | 1 | Ignore per-pointer invert bit |
| hdr_free_loc | input | 1 | Transfer-wide free-local flag |
| ptr_valid | input | 1 | Pointer descriptor valid |
| ptr_ready | output | 1 | Pointer descriptor accepted this cycle when valid |
| ptr_inv | input | 1 | Per-pointer invert bit |
| ptr_back | input | 4 | Backup count in 128-byte blocks |
| ptr_pool | input | 3 | Destination free pool |
| ptr_addr | input | 36 | Byte address of the pointer |
| rel_valid | output | 1 | Release request valid |
| rel_ready | input | 1 | Release request taken |
| rel_addr | output | 36 | Start address of the released buffer |
| rel_pool | output | 3 | Pool for the released buffer |
| err_underflow | output | 1 | One-cycle pulse: backup underflow on a release |

## Verification
The hardest case to reach is a stalled request with a second pointer already waiting. At that point the stall must hold the first request unchanged and hold off the second until the pool side resumes. The bench lowers rel_ready, lets one releasing pointer in, and then presents a second pointer. It checks ptr_ready, the held address and the held pool over several cycles before it raises rel_ready again. The underflow boundary also needs care. The bench drives a backup equal to the block index, which gives address 0, and a backup one larger, and it repeats the larger backup on a pointer that is not released.

// File: rtl/buf_release_pkg.sv
package buf_release_pkg;

    localparam int ADDR_W    = 36;
    localparam int BLK_SHIFT = 7;
    localparam int BACK_W    = 4;
    localparam int POOL_W    = 3;

    typedef enum logic [1:0] {
        KIND_OUTB = 2'd0,
        KIND_INB  = 2'd1,
        KIND_INTL = 2'd2,
        KIND_EXTL = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/buf_rel_decide.sv
module buf_rel_decide
    import buf_release_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       ign_inv,
    input  logic       free_loc,
    input  logic       inv,
    output logic       release_o
);
    logic per_ptr;

    always_comb begin
        per_ptr   = ign_inv ? free_loc : (free_loc ^ inv);
        release_o = (xfer_kind_e'(kind) == KIND_OUTB) && per_ptr;
    end
endmodule

// File: rtl/buf_rel_addr.sv
module buf_rel_addr #(
    parameter int AW     = 36,
    parameter int SHIFT  = 7,
    parameter int BW     = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] back,
    output logic [AW-1:0] start,
    output logic          underflow
);
    localparam int IDX_W = AW - SHIFT;

    logic [IDX_W:0] diff;

    always_comb begin
        diff      = {1'b0, addr[AW-1:SHIFT]} - {{(IDX_W+1-BW){1'b0}}, back};
        underflow = diff[IDX_W];
        start     = {diff[IDX_W-1:0], {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/buf_release_unit.sv
module buf_release_unit
    import buf_release_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SHIFT = BLK_SHIFT,
    parameter int BW    = BACK_W,
    parameter int PW    = POOL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    hdr_kind,
    input  logic          hdr_ign_inv,
    input  logic          hdr_free_loc,
    input  logic          ptr_valid,
    output logic          ptr_ready,
    input  logic          ptr_inv,
    input  logic [BW-1:0] ptr_back,
    input  logic [PW-1:0] ptr_pool,
    input  logic [AW-1:0] ptr_addr,
    output logic          rel_valid,
    input  logic          rel_ready,
    output logic [AW-1:0] rel_addr,
    output logic [PW-1:0] rel_pool,
    output logic          err_underflow
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [PW-1:0] pool;
        logic          err;
    } out_state_t;

    out_state_t st_d, st_q;

    logic          do_release;
    logic [AW-1:0] start_addr;
    logic          uflow;
    logic          accept;

    buf_rel_decide u_decide (
        .kind      (hdr_kind),
        .ign_inv   (hdr_ign_inv),
        .free_loc  (hdr_free_loc),
        .inv       (ptr_inv),
        .release_o (do_release)
    );

    buf_rel_addr #(.AW(AW), .SHIFT(SHIFT), .BW(BW)) u_addr (
        .addr      (ptr_addr),
        .back      (ptr_back),
        .start     (start_addr),
        .underflow (uflow)
    );

    assign ptr_ready = !st_q.vld || rel_ready;
    assign accept    = ptr_valid && ptr_ready;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.vld && rel_ready) begin
            st_d.vld = 1'b0;
        end
        if (accept && do_release) begin
            if (uflow) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.addr = start_addr;
                st_d.pool = ptr_pool;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_valid     = st_q.vld;
    assign rel_addr      = st_q.addr;
    assign rel_pool      = st_q.pool;
    assign err_underflow = st_q.err;
endmodule

// File: rtl/buf_release_chk.sv
module buf_release_chk #(
    parameter int AW = 36,
    parameter int BW = 4,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    hdr_kind,
    input logic          hdr_ign_inv,
    input logic          hdr_free_loc,
    input logic          ptr_valid,
    input logic          ptr_ready,
    input logic          ptr_inv,
    input logic [BW-1:0] ptr_back,
    input logic [PW-1:0] ptr_pool,
    input logic [AW-1:0] ptr_addr,
    input logic          rel_valid,
    input logic          rel_ready,
    input logic [AW-1:0] rel_addr,
    input logic [PW-1:0] rel_pool,
    input logic          err_underflow
);
    logic acc;
    assign acc = ptr_valid && ptr_ready;

    a_r1_no_release_non_outbound: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hdr_kind != 2'd0) |=> (!rel_valid && !err_underflow));

    a_r2_keep_when_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hdr_kind == 2'd0 && hdr_ign_inv && !hdr_free_loc) |=> (!rel_valid && !err_underflow));

    a_r3_xor_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hdr_kind == 2'd0 && !hdr_ign_inv) |=>
            ((rel_valid || err_underflow) == $past(hdr_free_loc ^ ptr_inv)));

    a_r5_pool_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hdr_kind == 2'd0 && hdr_ign_inv && hdr_free_loc) |=>
            ((rel_valid && rel_pool == $past(ptr_pool)) || err_underflow));

    a_r6_err_excludes_request: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> !rel_valid);

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_addr) && $stable(rel_pool)));

    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |-> !ptr_ready);

    a_r4_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_addr[6:0] == 7'd0));
endmodule

bind buf_release_unit buf_release_chk #(.AW(AW), .BW(BW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdr_kind(hdr_kind), .hdr_ign_inv(hdr_ign_inv),
    .hdr_free_loc(hdr_free_loc), .ptr_valid(ptr_valid), .ptr_ready(ptr_ready),
    .ptr_inv(ptr_inv), .ptr_back(ptr_back), .ptr_pool(ptr_pool), .ptr_addr(ptr_addr),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr),
    .rel_pool(rel_pool), .err_underflow(err_underflow)
);

// File: tb/test_buf_release_unit.sv
module test_buf_release_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [1:0]  kind;
        logic        ign;
        logic        fl;
        logic        inv;
        logic [3:0]  back;
        logic [2:0]  pool;
        logic [35:0] addr;
        logic        exp_free;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 1'b1, 1'b0, 4'd0,  3'd3, 36'h0_0000_1234, 1'b1},
        '{2'd0, 1'b1, 1'b1, 1'b1, 4'd2,  3'd5, 36'hF_FFFF_FFFF, 1'b1},
        '{2'd0, 1'b1, 1'b0, 1'b1, 4'd0,  3'd1, 36'h0_0000_8000, 1'b0},
        '{2'd0, 1'b0, 1'b1, 1'b0, 4'd1,  3'd7, 36'h0_0000_0100, 1'b1},
        '{2'd0, 1'b0, 1'b1, 1'b1, 4'd1,  3'd4, 36'h0_0000_4000, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 4'd3,  3'd2, 36'h1_2345_678F, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 4'd15, 3'd6, 36'h0_0000_007F, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  3'd1, 36'h0_0000_2000, 1'b0},
        '{2'd2, 1'b0, 1'b0, 1'b1, 4'd0,  3'd2, 36'h0_0000_3000, 1'b0},
        '{2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  3'd3, 36'h0_0000_5000, 1'b0},
        '{2'd0, 1'b1, 1'b1, 1'b0, 4'd5,  3'd6, 36'h0_0000_0200, 1'b1},
        '{2'd0, 1'b1, 1'b1, 1'b0, 4'd4,  3'd1, 36'h0_0000_027F, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  hdr_kind = '0;
    logic        hdr_ign_inv = 1'b0;
    logic        hdr_free_loc = 1'b0;
    logic        ptr_valid = 1'b0;
    logic        ptr_ready;
    logic        ptr_inv = 1'b0;
    logic [3:0]  ptr_back = '0;
    logic [2:0]  ptr_pool = '0;
    logic [35:0] ptr_addr = '0;
    logic        rel_valid;
    logic        rel_ready = 1'b1;
    logic [35:0] rel_addr;
    logic [2:0]  rel_pool;
    logic        err_underflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buf_release_unit i_buf_release_unit (
        .clk(clk), .rst_n(rst_n), .hdr_kind(hdr_kind), .hdr_ign_inv(hdr_ign_inv),
        .hdr_free_loc(hdr_free_loc), .ptr_valid(ptr_valid), .ptr_ready(ptr_ready),
        .ptr_inv(ptr_inv), .ptr_back(ptr_back), .ptr_pool(ptr_pool), .ptr_addr(ptr_addr),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr),
        .rel_pool(rel_pool), .err_underflow(err_underflow)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] start_of(input logic [35:0] a, input logic [3:0] b);
        logic [63:0] blk;
        blk = {28'd0, a} / 64'd128;
        return 36'((blk - 64'(b)) * 64'd128);
    endfunction

    function automatic bit under(input logic [35:0] a, input logic [3:0] b);
        return 64'(b) > ({28'd0, a} / 64'd128);
    endfunction

    task automatic drive(input vec_t v);
        hdr_kind = v.kind; hdr_ign_inv = v.ign; hdr_free_loc = v.fl;
        ptr_inv = v.inv; ptr_back = v.back; ptr_pool = v.pool; ptr_addr = v.addr;
        ptr_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 rel_valid after reset", 64'(rel_valid), 64'd0);
        check("R9 err after reset", 64'(err_underflow), 64'd0);
        check("R9 ptr_ready after reset", 64'(ptr_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            bit uf;
            uf = VEC[i].exp_free && under(VEC[i].addr, VEC[i].back);
            drive(VEC[i]);
            @(negedge clk);
            ptr_valid = 1'b0;
            // R1 R2 R3 R7: request presence; R6: error pulse
            check($sformatf("R1/R2/R3/R7 release vec%0d", i), 64'(rel_valid), 64'(VEC[i].exp_free && !uf));
            check($sformatf("R6/R7 err vec%0d", i), 64'(err_underflow), 64'(uf));
            if (VEC[i].exp_free && !uf) begin
                check($sformatf("R4 addr vec%0d", i), 64'(rel_addr), 64'(start_of(VEC[i].addr, VEC[i].back)));
                check($sformatf("R5 pool vec%0d", i), 64'(rel_pool), 64'(VEC[i].pool));
            end
            @(negedge clk);
            if (uf) check("R6 pulse one cycle", 64'(err_underflow), 64'd0);
        end

        // R8: stall with a second pointer waiting
        rel_ready = 1'b0;
        drive('{2'd0, 1'b1, 1'b1, 1'b0, 4'd1, 3'd2, 36'h0_0000_1000, 1'b1});
        @(negedge clk);
        drive('{2'd0, 1'b1, 1'b1, 1'b0, 4'd0, 3'd6, 36'h0_0000_3080, 1'b1});
        for (int k = 0; k < 3; k++) begin
            check("R8 stalled valid", 64'(rel_valid), 64'd1);
            check("R8 stalled addr", 64'(rel_addr), 64'h0F80);
            check("R8 stalled pool", 64'(rel_pool), 64'd2);
            check("R8 ptr_ready low", 64'(ptr_ready), 64'd0);
            @(negedge clk);
        end
        rel_ready = 1'b1;
        @(negedge clk);
        ptr_valid = 1'b0;
        check("R8 second valid", 64'(rel_valid), 64'd1);
        check("R8 second addr", 64'(rel_addr), 64'h3080);
        check("R8 second pool", 64'(rel_pool), 64'd6);
        @(negedge clk);
        check("R8 drained", 64'(rel_valid), 64'd0);

        // R9: reset clears a pending request
        rel_ready = 1'b0;
        drive('{2'd0, 1'b1, 1'b1, 1'b0, 4'd0, 3'd1, 36'h0_0000_4000, 1'b1});
        @(negedge clk);
        ptr_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears request", 64'(rel_valid), 64'd0);
        rst_n = 1'b1;
        rel_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule